// File: doc/BRIEF.md
# Interleaved First-Order Recursive Filter with Split Multiply-Add Loop

This block runs the first-order recursion y(n) = x(n) + a*y(n-1) for N separate data streams that take turns on one shared datapath. The feedback path holds N registers instead of one, so each stream's previous output comes back around the loop exactly when that stream's next slot arrives. One of those N registers sits between the coefficient multiplier and the adder. The longest combinational path is therefore either one multiply or one add, never both in series.

Every clock cycle is a slot that belongs to one stream. The slot tag steps through 0, 1, ..., N-1 and then starts again at 0. If a stream has no new sample in its slot, the strobe is held low. That stream's state then passes through unchanged. Each stream runs at one N-th of the clock rate, and the clock period does not depend on N. The coefficient is a signed Q1.(W-1) constant set by a parameter. The product is scaled back to W bits by an arithmetic right shift, which rounds toward minus infinity. The product and the sum both saturate to the W-bit signed range.

Top module: `nslow_iir1`

## Requirements
- R1: A synchronous active-high reset clears every loop register and the output valid flag. After reset, each stream starts from y(-1) = 0, so its first valid sample x comes out as exactly x.
- R2: out_valid equals in_valid from one clock earlier. When out_valid is high, out_y is the new result of the stream whose sample entered on that earlier cycle.
- R3: For each stream k, the sequence of valid outputs with tag k equals a separate single-stream reference, y = sat(x + sat(floor(y_prev * COEF / 2^(W-1)))), applied to stream k's valid samples alone.
- R4: If the sum x + scaled product leaves the signed W-bit range, the result is clamped to 2^(W-1)-1 or -2^(W-1). With W=16 and COEF=24576, two successive inputs of 32767 on one stream give 32767 both times, and two inputs of -32768 give -32768 both times.
- R5: In a slot where in_valid is low, out_valid is low one cycle later. That slot's stream keeps its state, so its next valid sample is combined with the last valid result.
- R6: Streams are isolated. A single active stream with N-1 idle slots between its samples follows the reference. The state of the other streams is not disturbed.
- R7: The product y*COEF is shifted right by W-1 bits with rounding toward minus infinity and saturated to W bits. With COEF=24576, a previous output of -1 followed by input 0 gives -1.
- R8: in_ch must advance by one modulo N on every cycle outside reset. out_ch equals in_ch from one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A new sample is present in this slot |
| in_ch | input | CW = $clog2(N) | Stream tag of this slot, rotating 0..N-1 |
| in_x | input | W | Signed input sample |
| out_valid | output | 1 | out_y holds a new result |
| out_ch | output | CW | Stream tag of the result |
| out_y | output | W | Signed filtered sample |

## Verification
The main check is a long stream of random slots in which about a quarter of the slots are idle and the sample values are random. It shows that each stream's result depends only on that stream's own history, and that an idle slot holds state rather than feeding zero into the recursion. A lone active stream with all other slots idle shows that the loop delay matches N exactly: a loop one register short or long would pair samples with the wrong stream's state. Directed full-scale runs separate saturating behaviour from wrap-around. A sign-crossing case with small negative values separates a floor shift from truncation toward zero.

// File: rtl/nslow_iir_pkg.sv
package nslow_iir_pkg;

    localparam int DEF_LANES = 4;
    localparam int DEF_WIDTH = 16;
    localparam int DEF_COEF  = 24576;   // 0.75 in Q1.15

    // clamp a wide signed value into the signed range of w bits
    function automatic longint clamp_w(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/iir_delay_line.sv
module iir_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] d,
    output logic signed [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_chain
            logic signed [W-1:0] tap [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)         tap[i] <= '0;
                    else if (i == 0) tap[i] <= d;
                    else             tap[i] <= tap[(i == 0) ? 0 : i - 1];
                end
            end
            assign q = tap[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/iir_coef_mul.sv
module iir_coef_mul
    import nslow_iir_pkg::*;
#(
    parameter int W    = 16,
    parameter int COEF = 24576
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] y_in,
    output logic signed [W-1:0] prod_q,   // sat(floor(y*COEF / 2^(W-1)))
    output logic signed [W-1:0] y_q       // y_in delayed alongside
);
    longint              full;
    logic signed [W-1:0] scaled;

    always_comb begin
        full   = longint'(y_in) * longint'(COEF);
        scaled = W'(clamp_w(full >>> (W - 1), W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            y_q    <= '0;
        end else begin
            prod_q <= scaled;
            y_q    <= y_in;
        end
    end
endmodule

// File: rtl/nslow_iir1.sv
module nslow_iir1
    import nslow_iir_pkg::*;
#(
    parameter int N    = DEF_LANES,
    parameter int W    = DEF_WIDTH,
    parameter int COEF = DEF_COEF,
    parameter int CW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [CW-1:0]        in_ch,
    input  logic signed [W-1:0]  in_x,
    output logic                 out_valid,
    output logic [CW-1:0]        out_ch,
    output logic signed [W-1:0]  out_y
);
    localparam int MID_DEPTH = N - 2;   // loop regs besides output and product regs

    typedef struct packed {
        logic                valid;
        logic [CW-1:0]       ch;
        logic signed [W-1:0] y;
    } slot_t;

    slot_t               head_q;
    slot_t               head_d;
    logic signed [W-1:0] mid_y;
    logic signed [W-1:0] prod;
    logic signed [W-1:0] y_back;

    // adder stage: new result, or hold the stream's state in an idle slot
    always_comb begin
        head_d.valid = in_valid;
        head_d.ch    = in_ch;
        head_d.y     = in_valid
                     ? W'(clamp_w(longint'(in_x) + longint'(prod), W))
                     : y_back;
    end

    always_ff @(posedge clk) begin
        if (rst) head_q <= '0;
        else     head_q <= head_d;
    end

    iir_delay_line #(.W(W), .DEPTH(MID_DEPTH)) u_mid (
        .clk (clk),
        .rst (rst),
        .d   (head_q.y),
        .q   (mid_y)
    );

    iir_coef_mul #(.W(W), .COEF(COEF)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .y_in   (mid_y),
        .prod_q (prod),
        .y_q    (y_back)
    );

    assign out_valid = head_q.valid;
    assign out_ch    = head_q.ch;
    assign out_y     = head_q.y;
endmodule

// File: rtl/nslow_iir1_chk.sv
module nslow_iir1_chk #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [CW-1:0] in_ch,
    input logic          out_valid,
    input logic [CW-1:0] out_ch
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> !out_valid);

    p_tag_follow_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_ch == $past(in_ch));

    p_rotate_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> int'(in_ch) == ((int'($past(in_ch)) + 1) % N));
endmodule

bind nslow_iir1 nslow_iir1_chk #(.N(N), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ch     (in_ch),
    .out_valid (out_valid),
    .out_ch    (out_ch)
);

// File: tb/nslow_iir1_test.sv
module nslow_iir1_test;
    localparam int N    = 4;
    localparam int W    = 16;
    localparam int COEF = 24576;
    localparam int CW   = $clog2(N);
    localparam longint HI = (longint'(1) <<< (W - 1)) - 1;
    localparam longint LO = -(longint'(1) <<< (W - 1));

    logic                clk = 0;
    logic                rst = 1;
    logic                in_valid = 0;
    logic [CW-1:0]       in_ch = '0;
    logic signed [W-1:0] in_x = '0;
    logic                out_valid;
    logic [CW-1:0]       out_ch;
    logic signed [W-1:0] out_y;

    longint model [N];
    int     slot;
    int     total = 0;
    int     bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    nslow_iir1 #(.N(N), .W(W), .COEF(COEF)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch), .in_x(in_x),
        .out_valid(out_valid), .out_ch(out_ch), .out_y(out_y)
    );

    function automatic longint sat(input longint v);
        return (v > HI) ? HI : ((v < LO) ? LO : v);
    endfunction

    function automatic longint ref_next(input longint yp, input longint x);
        return sat(x + sat((yp * COEF) >>> (W - 1)));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // call at a falling edge; returns at the next falling edge after checking
    task automatic step(input bit v, input longint x, input string req);
        int ch;
        ch       = slot;
        in_valid = v;
        in_ch    = CW'(ch);
        in_x     = W'(x);
        if (v) model[ch] = ref_next(model[ch], x);
        @(negedge clk);
        check("R2 valid", longint'(out_valid), longint'(v));
        check("R8 tag", longint'(out_ch), longint'(ch));
        if (v) check(req, longint'(out_y), model[ch]);
        else   check("R5 idle", longint'(out_valid), 0);
        slot = (slot + 1) % N;
    endtask

    task automatic do_reset();
        rst      = 1;
        in_valid = 0;
        in_ch    = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", longint'(out_valid), 0);
        rst  = 0;
        slot = 0;
        for (int i = 0; i < N; i++) model[i] = 0;
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic signed [W-1:0] r;
        void'($urandom(32'd20240613));
        @(negedge clk);
        do_reset();

        // R1: first sample of each stream passes unchanged
        for (int i = 0; i < N; i++) step(1, 100 * (i + 1) - 250, "R1");
        check("R1 first pass", longint'(out_y), 100 * N - 250);

        // R4: positive and negative saturation, on separate streams
        do_reset();
        for (int k = 0; k < 2; k++) begin
            step(1, HI, "R4");
            step(1, LO, "R4");
            step(0, 0, "R5");
            step(0, 0, "R5");
        end
        check("R4 neg clamp", model[1], LO);

        // R7: floor shift, -1 stays -1 on stream 0
        do_reset();
        step(1, -1, "R7");
        for (int i = 1; i < N; i++) step(0, 0, "R5");
        step(1, 0, "R7");
        check("R7 floor", longint'(out_y), -1);

        // R5: idle slot holds state of stream 0
        do_reset();
        step(1, 1000, "R5");
        for (int i = 1; i < N; i++) step(1, 7, "R5");
        for (int i = 0; i < N; i++) step(0, 0, "R5");
        step(1, 0, "R5");
        check("R5 held", longint'(out_y), 750);

        // R6: lone stream 2, others idle, then probe others
        do_reset();
        for (int k = 0; k < 6; k++)
            for (int i = 0; i < N; i++) step(i == 2, (i == 2) ? 4000 - 900 * k : 0, "R6");
        for (int i = 0; i < N; i++) step(1, 0, "R6");

        // R3: random mixed traffic
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            r = W'($urandom);
            step(($urandom % 4) != 0, longint'(r) >>> ($urandom % 4), "R3");
        end

        in_valid = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule